// File: doc/BRIEF.md
# Integer Condition-Code Generator

This block takes one integer arithmetic operation (add, subtract, compare, add with extend, or subtract with extend) and computes the result and a five-bit condition-code vector. The operands can be byte, word or long. The result and flags are evaluated only over the selected width. Bits of the operands above that width are ignored, and bits of the result above it read as zero.

The block is purely combinational, so the result and flags are valid in the same cycle as the inputs. A pipeline stage around it decides when to capture them. For the extend variants, the incoming extend flag is the carry-in or borrow-in. The previous zero flag is an input so that a chain of multi-word operations can only clear Z and never set it.

Top module: `alu_ccgen`

## Requirements
- R1: N (flags bit 3) equals the most significant bit of the result at the selected width.
- R2: For add, subtract and compare, Z (flags bit 2) is 1 exactly when the result at the selected width is zero.
- R3: `size` selects the width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits. `result` holds the low width bits of the operation, and all bits above the width are 0.
- R4: Add (`op`=0) forms a+b. C (bit 0) is the unsigned carry out of the width. V (bit 1) is set when both operands have the same sign and the result's sign differs from it.
- R5: Subtract (`op`=1) and compare (`op`=2) form a-b. C is set when a is unsigned-less than b at the width. V is set when the operands differ in sign and the result's sign differs from a's sign.
- R6: Add with extend (`op`=3) forms a+b+x_in. C is the carry out (with x_in=1: result<=b unsigned; with x_in=0: result<b), and V follows the add rule.
- R7: Subtract with extend (`op`=4) forms a-(b+x_in). C is set when a < b+x_in unsigned (with x_in=1: a<=b; with x_in=0: a<b), and V follows the subtract rule.
- R8: For both extend operations, Z equals the computed zero condition ANDed with `z_prev`.
- R9: X (bit 4) equals C for operations 0, 1, 3 and 4. Compare leaves X equal to `x_in`.
- R10: Op codes 5 to 7 are not operations. They give `result`=0 and flags {x_in, 0, z_prev, 0, 0}.

Port order of `flags` is {X, N, Z, V, C}, bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 3 | Operation code: 0 add, 1 sub, 2 compare, 3 add-extend, 4 sub-extend |
| size | input | 2 | Operand width select: 0 byte, 1 word, 2/3 long |
| opa | input | 32 | First operand (minuend for subtract) |
| opb | input | 32 | Second operand (subtrahend for subtract) |
| x_in | input | 1 | Incoming extend flag |
| z_prev | input | 1 | Previous zero flag |
| result | output | 32 | Arithmetic result, zero above the width |
| flags | output | 5 | New flags {X, N, Z, V, C} |

## Verification
The block holds no state, so any wrong internal term appears at the ports in the same cycle as the inputs that expose it. The most likely faults are a sign or carry tapped at the wrong bit position, or a width mask that lets upper operand bits leak through. These only appear at the byte and word widths, and only when the upper bits are non-zero. The random vectors therefore fill all 32 operand bits at every width. Directed vectors cover the cases where the sign boundary is crossed and where the extend carry-in makes the difference between carry and no carry, or between zero and non-zero.

// File: rtl/alu_ccgen.sv
module alu_ccgen #(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          x_in,
  input  logic          z_prev,
  output logic [DW-1:0] result,
  output logic [4:0]    flags
);
  localparam int MW = $clog2(DW);

  logic [DW-1:0] mask;
  logic [MW-1:0] msb;
  always_comb begin
    case (size)
      2'd0:    begin mask = DW'(8'hFF);     msb = MW'(7);  end
      2'd1:    begin mask = DW'(16'hFFFF);  msb = MW'(15); end
      default: begin mask = '1;             msb = MW'(DW-1); end
    endcase
  end

  logic [DW:0] a_e, b_e, sum, dif;
  assign a_e = {1'b0, opa & mask};
  assign b_e = {1'b0, opb & mask};
  assign sum = a_e + b_e + {{DW{1'b0}}, (op == 3'd3) & x_in};
  assign dif = a_e - b_e - {{DW{1'b0}}, (op == 3'd4) & x_in};

  logic is_add, is_sub, is_ext, valid_op;
  assign is_add   = (op == 3'd0) || (op == 3'd3);
  assign is_sub   = (op == 3'd1) || (op == 3'd2) || (op == 3'd4);
  assign is_ext   = (op == 3'd3) || (op == 3'd4);
  assign valid_op = is_add || is_sub;

  logic [DW-1:0] res;
  logic cy, sa, sb, n, z, v;
  assign res = is_add ? (sum[DW-1:0] & mask) : (dif[DW-1:0] & mask);
  assign cy  = is_add ? ((sum & ~{1'b0, mask}) != '0) : dif[DW];
  assign sa  = opa[msb];
  assign sb  = opb[msb];
  assign n   = res[msb];
  assign z   = (res == '0);
  assign v   = is_add ? ((sa == sb) && (n != sa)) : ((sa != sb) && (n != sa));

  always_comb begin
    if (!valid_op) begin
      result = '0;
      flags  = {x_in, 1'b0, z_prev, 1'b0, 1'b0};
    end else begin
      result = res;
      flags  = {(op == 3'd2) ? x_in : cy, n, is_ext ? (z & z_prev) : z, v, cy};
    end
  end

  always_comb begin
    AST_UPPER_ZERO: assert ((result & ~mask) == '0);                       // R3
    AST_NZ_EXCL: assert (!(flags[3] && flags[2]));                          // R1
    if (is_ext && !z_prev)
      AST_Z_STICKY: assert (!flags[2]);                                     // R8
    if (op == 3'd2)
      AST_CMP_KEEPS_X: assert (flags[4] == x_in);                           // R9
    if (valid_op && op != 3'd2)
      AST_X_TRACKS_C: assert (flags[4] == flags[0]);                        // R9
    if (!valid_op)
      AST_BAD_OP_QUIET: assert (result == '0 && flags[3] == 1'b0 && flags[1:0] == 2'b00); // R10
  end
endmodule

// File: tb/alu_ccgen_bench.sv
module alu_ccgen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] opa, opb;
  logic        x_in, z_prev;
  logic [31:0] result;
  logic [4:0]  flags;

  alu_ccgen u_alu_ccgen (.op(op), .size(size), .opa(opa), .opb(opb),
                         .x_in(x_in), .z_prev(z_prev), .result(result), .flags(flags));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic longint sx(longint v, int w);
    return v[w-1] ? v - (longint'(1) <<< w) : v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s op=%0d size=%0d a=%h b=%h x=%0d zp=%0d act=%h exp=%h",
               tag, op, size, opa, opb, x_in, z_prev, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic x, input logic zp);
    int w; longint m, ua, ub, r, sv, lo, hi;
    bit c, v, xe, ze;
    @(posedge clk); #1;
    op = o; size = s; opa = a; opb = b; x_in = x; z_prev = zp;
    w  = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    m  = (longint'(1) <<< w) - 1;
    ua = longint'(a) & m; ub = longint'(b) & m;
    lo = -(longint'(1) <<< (w-1)); hi = (longint'(1) <<< (w-1)) - 1;
    @(negedge clk);
    if (o > 4) begin
      chk("R10 result", longint'(result), 0);
      chk("R10 flags", longint'(flags), longint'({x, 1'b0, zp, 1'b0, 1'b0}));
    end else begin
      if (o == 0 || o == 3) begin
        r  = ua + ub + ((o == 3) ? longint'(x) : 0);
        c  = r > m;
        sv = sx(ua, w) + sx(ub, w) + ((o == 3) ? longint'(x) : 0);
      end else begin
        r  = ua - ub - ((o == 4) ? longint'(x) : 0);
        c  = ua < ub + ((o == 4) ? longint'(x) : 0);
        sv = sx(ua, w) - sx(ub, w) - ((o == 4) ? longint'(x) : 0);
      end
      r  = r & m;
      v  = (sv < lo) || (sv > hi);
      ze = (r == 0);
      if (o >= 3) ze = ze & zp;
      xe = (o == 2) ? x : c;
      chk("R3 result", longint'(result), r);
      chk("R1 N", longint'(flags[3]), (r >>> (w-1)) & 1);
      chk((o >= 3) ? "R8 Z" : "R2 Z", longint'(flags[2]), longint'(ze));
      chk(o == 0 ? "R4 C" : o == 3 ? "R6 C" : o == 4 ? "R7 C" : "R5 C", longint'(flags[0]), longint'(c));
      chk(o == 0 ? "R4 V" : o == 3 ? "R6 V" : o == 4 ? "R7 V" : "R5 V", longint'(flags[1]), longint'(v));
      chk("R9 X", longint'(flags[4]), longint'(xe));
    end
  endtask

  initial begin
    op = 0; size = 0; opa = 0; opb = 0; x_in = 0; z_prev = 0;
    // zero inputs: add of zeros gives Z only
    apply(3'd0, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
    chk("R2 idle flags", longint'(flags), 5'b00100);
    // directed corners per width
    apply(3'd0, 2'd0, 32'hFFFF_FF7F, 32'h0000_0001, 0, 0); // byte signed overflow
    apply(3'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 0, 0); // word carry, zero
    apply(3'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, 0, 0); // byte sub overflow
    apply(3'd2, 2'd2, 32'h0000_0001, 32'h0000_0002, 1, 0); // compare borrow, X kept
    apply(3'd2, 2'd2, 32'h0000_0005, 32'h0000_0001, 1, 0);
    apply(3'd3, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1, 1); // carry only via x
    apply(3'd3, 2'd0, 32'h0000_00FF, 32'h0000_0000, 0, 1);
    apply(3'd3, 2'd1, 32'h0000_0000, 32'h0000_0000, 0, 0); // zero never sets Z
    apply(3'd3, 2'd1, 32'h0000_0000, 32'h0000_0000, 0, 1); // zero keeps Z
    apply(3'd4, 2'd2, 32'h0000_0003, 32'h0000_0003, 1, 1); // a<=b borrow with x
    apply(3'd4, 2'd2, 32'h0000_0003, 32'h0000_0003, 0, 1); // equal, no x -> zero
    apply(3'd4, 2'd0, 32'h1234_5600, 32'h0000_00FF, 0, 1);
    apply(3'd5, 2'd2, 32'h1234_5678, 32'h1, 1, 1);
    apply(3'd7, 2'd0, 32'hFFFF_FFFF, 32'h1, 0, 0);
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 150; k++)
          apply(3'(o), 2'(s), $urandom, (k % 5 == 0) ? $urandom & 32'hF : $urandom,
                1'($urandom), 1'($urandom));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule